// File: doc/BRIEF.md
# Flash Protected-Range Access Checker

This block sits in front of a serial-flash cycle engine. It decides whether each pending flash cycle may run. It holds a small bank of protected-range registers that software writes over a simple indexed register bus. Each range names a lower and an upper 4 KiB page of the flash address space. Each range can guard against reads, against writes and erases, or against both.

When the cycle engine has a cycle ready, it presents the start address, the byte count and the access kind for one clock. One clock later the block answers with exactly one of two outcomes: allow or error. The engine starts the cycle on the SPI pins only on allow.

Protection is inactive until a one-way configuration lock is set. Before the lock, every cycle is allowed and the ranges may be rewritten freely. Once locked, the ranges are frozen and the checks are enforced. Both stay that way until reset.

Top module: `flash_range_guard`

## Requirements
- R1: After reset, every range register reads as zero, `locked` is 0, and `chk_done`, `chk_allow` and `chk_error` are 0.
- R2: While unlocked, a write with `reg_wr` high stores `reg_wdata` in range `reg_idx`, and `reg_rdata` shows it. Bits 30:29 and 14:13 always read as zero. An index at or above the number of ranges reads as zero, and writes to it are dropped.
- R3: A cycle with `lock_req` high sets `locked` on the next clock. Only reset clears it. While locked, register writes are ignored and the stored ranges keep their values.
- R4: While `locked` is 0, every checked cycle is allowed, whatever the ranges hold.
- R5: Bit 31 of a range enables write protection. Once locked, a write or erase cycle (`chk_write`=1) that touches any byte of an enabled range is blocked. Bit 31 has no effect on read cycles.
- R6: Bit 15 of a range enables read protection. Once locked, a read cycle (`chk_write`=0) that touches any byte of an enabled range is blocked. Bit 15 has no effect on write cycles.
- R7: A range covers addresses from {bits 12:0, 12'h000} through {bits 28:16, 12'hFFF}, with both bounds inclusive.
- R8: A cycle touches the bytes `chk_addr` through `chk_addr`+`chk_len`-1. Any overlap with a range blocks the cycle. A byte count of zero touches nothing and is never blocked.
- R9: All ranges are checked in parallel, and a hit in any one of them blocks the cycle. A range whose lower page lies above its upper page covers nothing.
- R10: `chk_done` is high exactly on the clock after a cycle with `chk_valid` high. When `chk_done` is high, exactly one of `chk_allow` and `chk_error` is high. When `chk_done` is low, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 3 | Range register index |
| reg_wr | input | 1 | Write strobe for the indexed range |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Contents of the indexed range |
| lock_req | input | 1 | Sets the one-way lock |
| locked | output | 1 | Lock state |
| chk_valid | input | 1 | A cycle is presented for checking |
| chk_addr | input | 24 | Start address of the cycle |
| chk_len | input | 7 | Byte count of the cycle |
| chk_write | input | 1 | 1 for write or erase, 0 for read |
| chk_done | output | 1 | Verdict is valid |
| chk_allow | output | 1 | The cycle may start |
| chk_error | output | 1 | The cycle is blocked and flagged as a cycle error |

## Verification
Each result has a fixed due time:
- The verdict for a presented cycle is registered once, so it appears at the first clock edge after `chk_valid`. The bench presents at a falling edge and samples at the next falling edge.
- `locked` also appears one edge after `lock_req`.
- Register readback is combinational from the stored value, so it is sampled a short delay after the index changes. It is always sampled after the write edge that stored the value.

Expected verdicts come from a byte-by-byte walk over each range in a bench model. This keeps the expected values independent of the interval compare used in the design.

// File: rtl/frg_pkg.sv
package frg_pkg;

   localparam int WORD_W   = 32;
   localparam int PAGE_SH  = 12;
   localparam int LIM_W    = 13;
   localparam int SPAN_W   = LIM_W + PAGE_SH + 1;
   localparam int WP_POS   = 31;
   localparam int HI_LSB   = 16;
   localparam int RP_POS   = 15;
   localparam int LO_LSB   = 0;

   typedef struct packed {
      logic             wp;
      logic [LIM_W-1:0] hi;
      logic             rp;
      logic [LIM_W-1:0] lo;
   } range_t;

   function automatic logic [WORD_W-1:0] range_to_word(input range_t r);
      logic [WORD_W-1:0] w;
      w = '0;
      w[WP_POS]                 = r.wp;
      w[HI_LSB +: LIM_W]        = r.hi;
      w[RP_POS]                 = r.rp;
      w[LO_LSB +: LIM_W]        = r.lo;
      return w;
   endfunction

   function automatic range_t word_to_range(input logic [WORD_W-1:0] w);
      range_t r;
      r.wp = w[WP_POS];
      r.hi = w[HI_LSB +: LIM_W];
      r.rp = w[RP_POS];
      r.lo = w[LO_LSB +: LIM_W];
      return r;
   endfunction

endpackage

// File: rtl/frg_regfile.sv
module frg_regfile
   import frg_pkg::*;
#(
   parameter int NUM_RANGES    = 5,
   parameter int IDX_W         = 3,
   parameter bit HAS_READ_PROT = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [IDX_W-1:0]             idx,
   input  logic [WORD_W-1:0]            wdata,
   input  logic                         frozen,
   output range_t [NUM_RANGES-1:0]      ranges,
   output logic [WORD_W-1:0]            rdata
);

   range_t wr_view;
   assign wr_view = word_to_range(wdata);

   for (genvar g = 0; g < NUM_RANGES; g++) begin : g_slot
      logic sel;
      assign sel = wr_en && !frozen && (idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ranges[g].wp <= 1'b0;
            ranges[g].hi <= '0;
            ranges[g].lo <= '0;
         end else if (sel) begin
            ranges[g].wp <= wr_view.wp;
            ranges[g].hi <= wr_view.hi;
            ranges[g].lo <= wr_view.lo;
         end
      end

      if (HAS_READ_PROT) begin : g_rp
         always_ff @(posedge clk) begin
            if (!rst_n)
               ranges[g].rp <= 1'b0;
            else if (sel)
               ranges[g].rp <= wr_view.rp;
         end
      end else begin : g_no_rp
         assign ranges[g].rp = 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_RANGES; i++) begin
         if (idx == IDX_W'(i))
            rdata = range_to_word(ranges[i]);
      end
   end

endmodule

// File: rtl/frg_span.sv
module frg_span
   import frg_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int LEN_W  = 7
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   output logic [SPAN_W-1:0] first,
   output logic [SPAN_W-1:0] last,
   output logic              nonempty
);

   assign first    = SPAN_W'(addr);
   assign last     = first + SPAN_W'(len) - SPAN_W'(1);
   assign nonempty = (len != '0);

endmodule

// File: rtl/frg_range_match.sv
module frg_range_match
   import frg_pkg::*;
(
   input  range_t            rng,
   input  logic [SPAN_W-1:0] first,
   input  logic [SPAN_W-1:0] last,
   output logic              hit_rd,
   output logic              hit_wr
);

   logic [SPAN_W-1:0] lo_addr;
   logic [SPAN_W-1:0] hi_addr;
   logic              well_formed;
   logic              overlap;

   assign lo_addr     = {1'b0, rng.lo, {PAGE_SH{1'b0}}};
   assign hi_addr     = {1'b0, rng.hi, {PAGE_SH{1'b1}}};
   assign well_formed = (rng.lo <= rng.hi);
   assign overlap     = well_formed && (first <= hi_addr) && (last >= lo_addr);

   assign hit_rd = overlap && rng.rp;
   assign hit_wr = overlap && rng.wp;

endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
   import frg_pkg::*;
#(
   parameter int NUM_RANGES    = 5,
   parameter int ADDR_W        = 24,
   parameter int LEN_W         = 7,
   parameter bit HAS_READ_PROT = 1'b1,
   localparam int IDX_W        = $clog2(NUM_RANGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              lock_req,
   output logic              locked,
   input  logic              chk_valid,
   input  logic [ADDR_W-1:0] chk_addr,
   input  logic [LEN_W-1:0]  chk_len,
   input  logic              chk_write,
   output logic              chk_done,
   output logic              chk_allow,
   output logic              chk_error
);

   if (NUM_RANGES < 2 || NUM_RANGES > 16) begin : g_bad_ranges
      $error("flash_range_guard: NUM_RANGES must be 2..16");
   end
   if (ADDR_W <= PAGE_SH || ADDR_W > LIM_W + PAGE_SH) begin : g_bad_addr
      $error("flash_range_guard: ADDR_W must be 13..25");
   end
   if (LEN_W < 1 || LEN_W >= ADDR_W) begin : g_bad_len
      $error("flash_range_guard: LEN_W must be 1..ADDR_W-1");
   end

   range_t [NUM_RANGES-1:0] ranges;
   logic   [SPAN_W-1:0]     first;
   logic   [SPAN_W-1:0]     last;
   logic                    nonempty;
   logic   [NUM_RANGES-1:0] hit_rd;
   logic   [NUM_RANGES-1:0] hit_wr;
   logic                    blocked;

   always_ff @(posedge clk) begin
      if (!rst_n)
         locked <= 1'b0;
      else if (lock_req)
         locked <= 1'b1;
   end

   frg_regfile #(
      .NUM_RANGES   (NUM_RANGES),
      .IDX_W        (IDX_W),
      .HAS_READ_PROT(HAS_READ_PROT)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_wr),
      .idx   (reg_idx),
      .wdata (reg_wdata),
      .frozen(locked),
      .ranges(ranges),
      .rdata (reg_rdata)
   );

   frg_span #(
      .ADDR_W(ADDR_W),
      .LEN_W (LEN_W)
   ) u_span (
      .addr    (chk_addr),
      .len     (chk_len),
      .first   (first),
      .last    (last),
      .nonempty(nonempty)
   );

   for (genvar g = 0; g < NUM_RANGES; g++) begin : g_match
      frg_range_match u_match (
         .rng   (ranges[g]),
         .first (first),
         .last  (last),
         .hit_rd(hit_rd[g]),
         .hit_wr(hit_wr[g])
      );
   end

   assign blocked = locked && nonempty && (chk_write ? (|hit_wr) : (|hit_rd));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_done  <= 1'b0;
         chk_allow <= 1'b0;
         chk_error <= 1'b0;
      end else begin
         chk_done  <= chk_valid;
         chk_allow <= chk_valid && !blocked;
         chk_error <= chk_valid && blocked;
      end
   end

endmodule

// File: rtl/frg_checker.sv
module frg_checker #(
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] reg_idx,
   input logic [31:0]      reg_rdata,
   input logic             lock_req,
   input logic             locked,
   input logic             chk_valid,
   input logic             chk_done,
   input logic             chk_allow,
   input logic             chk_error
);

   assert_done_follows_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |=> chk_done);

   assert_no_spurious_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |=> !chk_done);

   assert_single_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
      chk_done |-> ($countones({chk_allow, chk_error}) == 1));

   assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_done |-> (!chk_allow && !chk_error));

   assert_lock_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lock_req |=> locked);

   assert_lock_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);

   assert_frozen_ranges_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && $past(locked) && $stable(reg_idx)) |-> $stable(reg_rdata));

   assert_open_before_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && chk_valid) |=> !chk_error);

endmodule

bind flash_range_guard frg_checker #(.IDX_W(IDX_W)) u_frg_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_idx  (reg_idx),
   .reg_rdata(reg_rdata),
   .lock_req (lock_req),
   .locked   (locked),
   .chk_valid(chk_valid),
   .chk_done (chk_done),
   .chk_allow(chk_allow),
   .chk_error(chk_error)
);

// File: tb/flash_range_guard_test.sv
module flash_range_guard_test;

   localparam int NR = 5;
   localparam logic [31:0] KEEP = 32'h9FFF_9FFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_idx = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        lock_req = 1'b0;
   logic        locked;
   logic        chk_valid = 1'b0;
   logic [23:0] chk_addr = '0;
   logic [6:0]  chk_len = '0;
   logic        chk_write = 1'b0;
   logic        chk_done, chk_allow, chk_error;

   int n_checks = 0;
   int n_fails  = 0;
   logic [31:0] exp_regs [NR];
   bit exp_locked = 1'b0;

   always #4 clk = ~clk;

   flash_range_guard uut (
      .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lock_req(lock_req),
      .locked(locked), .chk_valid(chk_valid), .chk_addr(chk_addr),
      .chk_len(chk_len), .chk_write(chk_write), .chk_done(chk_done),
      .chk_allow(chk_allow), .chk_error(chk_error)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic bit model_blocked(input logic [23:0] a, input int len, input bit wr);
      if (!exp_locked) return 1'b0;
      for (int b = 0; b < len; b++) begin
         longint unsigned byte_a = longint'(a) + longint'(b);
         for (int r = 0; r < NR; r++) begin
            longint unsigned lo = longint'(exp_regs[r][12:0]) * 4096;
            longint unsigned hi = longint'(exp_regs[r][28:16]) * 4096 + 4095;
            bit en = wr ? exp_regs[r][31] : exp_regs[r][15];
            if (en && byte_a >= lo && byte_a <= hi) return 1'b1;
         end
      end
      return 1'b0;
   endfunction

   task automatic wr_reg(input int idx, input logic [31:0] d);
      @(negedge clk);
      reg_idx = 3'(idx); reg_wdata = d; reg_wr = 1'b1;
      if (!exp_locked && idx < NR) exp_regs[idx] = d & KEEP;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_check(input int idx, input string req);
      logic [31:0] e;
      @(negedge clk);
      reg_idx = 3'(idx);
      #1;
      e = (idx < NR) ? exp_regs[idx] : 32'h0;
      check(reg_rdata === e, req, reg_rdata, e);
   endtask

   task automatic do_chk(input logic [23:0] a, input int len, input bit wr, input string req);
      bit e;
      e = model_blocked(a, len, wr);
      @(negedge clk);
      chk_valid = 1'b1; chk_addr = a; chk_len = 7'(len); chk_write = wr;
      @(negedge clk);
      chk_valid = 1'b0;
      check(chk_done === 1'b1 && chk_error === e && chk_allow === !e, req,
            {29'h0, chk_done, chk_allow, chk_error}, {29'h0, 1'b1, !e, e});
   endtask

   initial begin
      #(8 * 200000);
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20251));
      for (int i = 0; i < NR; i++) exp_regs[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      #1;
      check(locked === 1'b0 && chk_done === 1'b0 && chk_allow === 1'b0 && chk_error === 1'b0,
            "R1", {28'h0, locked, chk_done, chk_allow, chk_error}, 32'h0);
      for (int i = 0; i < NR; i++) rd_check(i, "R1");

      // R2: reserved bits read zero, out-of-range index
      wr_reg(4, 32'hFFFF_FFFF);
      rd_check(4, "R2");
      wr_reg(6, 32'h8123_8456);
      rd_check(6, "R2");
      rd_check(5, "R2");
      for (int i = 0; i < 20; i++) begin
         int idx = $urandom_range(0, 7);
         wr_reg(idx, $urandom);
         rd_check(idx, "R2");
      end

      // R4: before lock nothing is blocked even with protecting ranges
      for (int i = 0; i < NR; i++) wr_reg(i, 32'h8FFF_8000);
      for (int i = 0; i < 20; i++)
         do_chk(24'($urandom), $urandom_range(0, 127), 1'($urandom), "R4");

      // Final range programming
      wr_reg(0, 32'h801F_0010);   // write-protect 0x010000..0x01FFFF
      wr_reg(1, 32'h0100_8100);   // read-protect  0x100000..0x100FFF
      wr_reg(2, 32'h88FF_8800);   // both          0x800000..0x8FFFFF
      wr_reg(3, 32'h8200_0300);   // inverted: covers nothing
      wr_reg(4, 32'h8FFF_0FFF);   // write-protect 0xFFF000..0xFFFFFF
      do_chk(24'h010000, 1, 1'b1, "R4");

      // R3: lock
      @(negedge clk); lock_req = 1'b1;
      @(negedge clk); lock_req = 1'b0; exp_locked = 1'b1;
      check(locked === 1'b1, "R3", {31'h0, locked}, 32'h1);
      wr_reg(0, 32'h0000_0000);
      rd_check(0, "R3");
      wr_reg(2, 32'h0000_0000);
      rd_check(2, "R3");

      // R5: write protection and read independence
      do_chk(24'h01FFFF, 1, 1'b1, "R5");
      do_chk(24'h010000, 1, 1'b0, "R5");
      do_chk(24'h8ABCDE, 4, 1'b1, "R5");
      do_chk(24'hFFFFFF, 1, 1'b1, "R5");
      do_chk(24'hFFFFFF, 1, 1'b0, "R5");
      // R6: read protection and write independence
      do_chk(24'h100000, 1, 1'b0, "R6");
      do_chk(24'h100000, 16, 1'b1, "R6");
      do_chk(24'h8ABCDE, 4, 1'b0, "R6");
      // R7: inclusive bounds
      do_chk(24'h00FFFF, 1, 1'b1, "R7");
      do_chk(24'h010000, 1, 1'b1, "R7");
      do_chk(24'h020000, 1, 1'b1, "R7");
      do_chk(24'h100FFF, 1, 1'b0, "R7");
      do_chk(24'h101000, 1, 1'b0, "R7");
      // R8: span and zero length
      do_chk(24'h00FFFF, 2, 1'b1, "R8");
      do_chk(24'h0FFFC0, 64, 1'b0, "R8");
      do_chk(24'h0FFFC0, 65, 1'b0, "R8");
      do_chk(24'h010000, 0, 1'b1, "R8");
      // R9: inverted range covers nothing; any range blocks
      do_chk(24'h250000, 8, 1'b1, "R9");
      do_chk(24'h300000, 1, 1'b1, "R9");
      do_chk(24'h7FFFF0, 32, 1'b0, "R9");
      // R10: idle after verdict
      @(negedge clk); #1;
      check(chk_done === 1'b0, "R10", {31'h0, chk_done}, 32'h0);

      // Random checks near range edges
      for (int i = 0; i < 400; i++) begin
         int r = $urandom_range(0, NR - 1);
         int base = int'(exp_regs[r][12:0]) * 4096;
         if ($urandom_range(0, 1) == 1) base = int'(exp_regs[r][28:16]) * 4096 + 4095;
         do_chk(24'(base + $urandom_range(0, 255) - 128), $urandom_range(0, 127),
                1'($urandom), "R9");
      end

      // R3: lock request again has no effect on frozen state
      @(negedge clk); lock_req = 1'b1;
      @(negedge clk); lock_req = 1'b0;
      check(locked === 1'b1, "R3", {31'h0, locked}, 32'h1);
      rd_check(4, "R3");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule